// File: doc/BRIEF.md
# Page Protection Decoder

This block turns the protection fields of a translated page into a read/write/execute permission vector. It then judges one access against that vector. A memory-management pipeline presents it with three kinds of input: the current privilege level, the protection bits of the matching segment entry, and the protection bits of the matching page-table entry. The pipeline also supplies the access type and two flags saying whether the segment lookup and the page-table lookup hit. All of this logic is combinational, so the permission vector, the violation flag and the fault encoding appear in the same cycle as the request.

A single key bit picks one of two decode tables for the 3-bit page protection code. That key comes from the segment entry, and which of its two key bits is used depends on privilege. Execute rights are removed by any of three no-execute sources. When an access faults, the block reports a fault class and a fixed 32-bit syndrome word. The syndrome values differ between instruction fetches and data accesses, and data writes set one extra bit. The address of a data-side fault is captured in a register at the next rising clock edge, where it stays until the next data-side fault.

Top module: `pgprot_top`

## Requirements
- R1: The key is `seg_key_sup_i` when `priv_i` is 1 (privileged) and `seg_key_user_i` when `priv_i` is 0.
- R2: The protection code is {`pte_pp_hi_i`, `pte_pp_i[1]`, `pte_pp_i[0]`}, with `pte_pp_hi_i` as the most significant bit.
- R3: `perm_o` bit 0 is read, bit 1 is write and bit 2 is execute. With key 0, codes 0, 1 and 2 give read and write, codes 3 and 6 give read only, and codes 4, 5 and 7 give neither.
- R4: With key 1, code 2 gives read and write, codes 1 and 3 give read only, and codes 0, 4, 5, 6 and 7 give neither.
- R5: `perm_o[2]` is 1 exactly when `pte_noexec_i`, `pte_guard_i` and `seg_noexec_i` are all 0, whatever the key and the code.
- R6: `acc_type_i` encodes 0 = read, 1 = write, 2 = fetch and 3 = read. `viol_o` is 1 exactly when `req_valid_i` is 1 and the permission bit needed by the access is 0 in `perm_o`.
- R7: Fault priority runs in this order: segment miss, fetch from a no-execute segment, page-table miss, rights violation. For a fetch the class is 1 (instruction storage), and the syndrome is 0x10000000 for a no-execute segment, 0x40000000 for a page-table miss and 0x08000000 for a rights violation.
- R8: For a data access (type 0, 1 or 3) the class is 2 (data storage). The syndrome is 0x40000000 for a page-table miss and 0x08000000 for a rights violation, and a write adds 0x02000000 to either value. A data access never gets the no-execute-segment fault.
- R9: A segment miss (`seg_hit_i` = 0 with `req_valid_i` = 1) raises `fault_o` with syndrome 0 and class 3 for a fetch or class 4 for a data access.
- R10: A data-side fault (class 2 or 4) loads `addr_i` into `fault_addr_o` at the next rising edge. All other cycles leave it unchanged, and reset clears it to 0.
- R11: When `fault_o` is 0, `syndrome_o` and `fault_class_o` are 0. When `req_valid_i` is 0, no fault and no violation are reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the fault address register |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | An access is being judged this cycle |
| acc_type_i | input | 2 | Access type: 0 read, 1 write, 2 fetch, 3 read |
| priv_i | input | 1 | 1 when privileged, 0 when unprivileged |
| addr_i | input | ADDR_W | Effective address of the access |
| seg_hit_i | input | 1 | The segment lookup found an entry |
| seg_key_user_i | input | 1 | Segment key bit used when unprivileged |
| seg_key_sup_i | input | 1 | Segment key bit used when privileged |
| seg_noexec_i | input | 1 | Segment no-execute bit |
| pte_hit_i | input | 1 | The page-table lookup found an entry |
| pte_pp_i | input | 2 | Low two bits of the protection code |
| pte_pp_hi_i | input | 1 | High bit of the protection code |
| pte_noexec_i | input | 1 | Page no-execute bit |
| pte_guard_i | input | 1 | Page guarded bit |
| perm_o | output | 3 | Permission vector {execute, write, read} |
| viol_o | output | 1 | The needed permission is missing |
| fault_o | output | 1 | Fault strobe |
| fault_class_o | output | 3 | 0 none, 1 instr storage, 2 data storage, 3 instr segment, 4 data segment |
| syndrome_o | output | 32 | Fault syndrome word |
| fault_addr_o | output | ADDR_W | Address of the last data-side fault |

## Verification
Most of the block is combinational. A wrong table entry, a wrong key choice or a wrong priority therefore shows at `perm_o`, `syndrome_o` or `fault_class_o` in the same cycle the inputs are applied. The bench walks every code under both keys and both privilege levels, so a single bad table cell cannot hide. The one piece of state is the fault address register. If it captures on the wrong condition, the error appears one edge later: the register takes up the address of a fetch fault or of a fault-free access, or it misses the address of a segment-miss data fault.

// File: rtl/pgprot_pkg.sv
`timescale 1ns/1ps
package pgprot_pkg;

  localparam int unsigned SYN_W  = 32;
  localparam int unsigned CODE_W = 3;
  localparam int unsigned PERM_W = 3;

  // perm vector bit positions
  localparam int unsigned PB_RD = 0;
  localparam int unsigned PB_WR = 1;
  localparam int unsigned PB_EX = 2;

  typedef enum logic [1:0] {
    ACC_RD  = 2'd0,
    ACC_WR  = 2'd1,
    ACC_FX  = 2'd2,
    ACC_RD2 = 2'd3
  } acc_e;

  typedef enum logic [2:0] {
    FC_NONE  = 3'd0,
    FC_ISTOR = 3'd1,
    FC_DSTOR = 3'd2,
    FC_ISEG  = 3'd3,
    FC_DSEG  = 3'd4
  } fclass_e;

  localparam logic [SYN_W-1:0] SYN_PTE_MISS = 32'h4000_0000;
  localparam logic [SYN_W-1:0] SYN_RIGHTS   = 32'h0800_0000;
  localparam logic [SYN_W-1:0] SYN_SEG_NX   = 32'h1000_0000;
  localparam logic [SYN_W-1:0] SYN_WR_FLAG  = 32'h0200_0000;

endpackage

// File: rtl/pgprot_key_sel.sv
`timescale 1ns/1ps
module pgprot_key_sel
  import pgprot_pkg::*;
(
  input  logic              priv_i,
  input  logic              key_user_i,
  input  logic              key_sup_i,
  input  logic [1:0]        pp_i,
  input  logic              pp_hi_i,
  output logic              key_o,
  output logic [CODE_W-1:0] code_o
);
  assign key_o  = priv_i ? key_sup_i : key_user_i;
  assign code_o = {pp_hi_i, pp_i};
endmodule

// File: rtl/pgprot_table.sv
`timescale 1ns/1ps
module pgprot_table
  import pgprot_pkg::*;
#(
  parameter bit KEY = 1'b0
) (
  input  logic [CODE_W-1:0] code_i,
  output logic              rd_o,
  output logic              wr_o
);
  always_comb begin
    rd_o = 1'b0;
    wr_o = 1'b0;
    if (!KEY) begin
      unique case (code_i)
        3'd0, 3'd1, 3'd2: begin rd_o = 1'b1; wr_o = 1'b1; end
        3'd3, 3'd6:       rd_o = 1'b1;
        default:          ;
      endcase
    end else begin
      unique case (code_i)
        3'd2:       begin rd_o = 1'b1; wr_o = 1'b1; end
        3'd1, 3'd3: rd_o = 1'b1;
        default:    ;
      endcase
    end
  end
endmodule

// File: rtl/pgprot_perm.sv
`timescale 1ns/1ps
module pgprot_perm
  import pgprot_pkg::*;
(
  input  logic              key_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              pte_nx_i,
  input  logic              pte_guard_i,
  input  logic              seg_nx_i,
  output logic [PERM_W-1:0] perm_o
);
  localparam int unsigned N_KEYS = 2;

  logic [N_KEYS-1:0] rd_k;
  logic [N_KEYS-1:0] wr_k;

  for (genvar k = 0; k < N_KEYS; k++) begin : g_tbl
    pgprot_table #(.KEY(k[0])) u_tbl (
      .code_i (code_i),
      .rd_o   (rd_k[k]),
      .wr_o   (wr_k[k])
    );
  end

  always_comb begin
    perm_o        = '0;
    perm_o[PB_RD] = rd_k[key_i];
    perm_o[PB_WR] = wr_k[key_i];
    perm_o[PB_EX] = ~(pte_nx_i | pte_guard_i | seg_nx_i);
  end
endmodule

// File: rtl/pgprot_fault.sv
`timescale 1ns/1ps
module pgprot_fault
  import pgprot_pkg::*;
(
  input  logic              req_i,
  input  logic [1:0]        acc_i,
  input  logic              seg_hit_i,
  input  logic              seg_nx_i,
  input  logic              pte_hit_i,
  input  logic [PERM_W-1:0] perm_i,
  output logic              viol_o,
  output logic              fault_o,
  output logic [2:0]        class_o,
  output logic [SYN_W-1:0]  syn_o,
  output logic              data_fault_o
);
  acc_e              acc;
  logic              is_fx;
  logic              is_wr;
  logic [PERM_W-1:0] need;
  logic [SYN_W-1:0]  wr_bits;
  fclass_e           cls;

  assign acc   = acc_e'(acc_i);
  assign is_fx = (acc == ACC_FX);
  assign is_wr = (acc == ACC_WR);

  always_comb begin
    need = '0;
    unique case (acc)
      ACC_WR:  need[PB_WR] = 1'b1;
      ACC_FX:  need[PB_EX] = 1'b1;
      default: need[PB_RD] = 1'b1;
    endcase
  end

  assign viol_o  = req_i & ~|(need & perm_i);
  assign wr_bits = is_wr ? SYN_WR_FLAG : '0;

  always_comb begin
    cls   = FC_NONE;
    syn_o = '0;
    if (req_i) begin
      if (!seg_hit_i) begin
        cls = is_fx ? FC_ISEG : FC_DSEG;
      end else if (is_fx && seg_nx_i) begin
        cls   = FC_ISTOR;
        syn_o = SYN_SEG_NX;
      end else if (!pte_hit_i) begin
        cls   = is_fx ? FC_ISTOR : FC_DSTOR;
        syn_o = SYN_PTE_MISS | wr_bits;
      end else if (viol_o) begin
        cls   = is_fx ? FC_ISTOR : FC_DSTOR;
        syn_o = SYN_RIGHTS | wr_bits;
      end
    end
  end

  assign class_o      = cls;
  assign fault_o      = (cls != FC_NONE);
  assign data_fault_o = (cls == FC_DSTOR) || (cls == FC_DSEG);
endmodule

// File: rtl/pgprot_top.sv
`timescale 1ns/1ps
module pgprot_top
  import pgprot_pkg::*;
#(
  parameter int unsigned ADDR_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [1:0]        acc_type_i,
  input  logic              priv_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              seg_hit_i,
  input  logic              seg_key_user_i,
  input  logic              seg_key_sup_i,
  input  logic              seg_noexec_i,
  input  logic              pte_hit_i,
  input  logic [1:0]        pte_pp_i,
  input  logic              pte_pp_hi_i,
  input  logic              pte_noexec_i,
  input  logic              pte_guard_i,
  output logic [2:0]        perm_o,
  output logic              viol_o,
  output logic              fault_o,
  output logic [2:0]        fault_class_o,
  output logic [31:0]       syndrome_o,
  output logic [ADDR_W-1:0] fault_addr_o
);
  logic              key;
  logic [CODE_W-1:0] code;
  logic              data_fault;
  logic [ADDR_W-1:0] fault_addr_q;

  pgprot_key_sel u_key (
    .priv_i     (priv_i),
    .key_user_i (seg_key_user_i),
    .key_sup_i  (seg_key_sup_i),
    .pp_i       (pte_pp_i),
    .pp_hi_i    (pte_pp_hi_i),
    .key_o      (key),
    .code_o     (code)
  );

  pgprot_perm u_perm (
    .key_i       (key),
    .code_i      (code),
    .pte_nx_i    (pte_noexec_i),
    .pte_guard_i (pte_guard_i),
    .seg_nx_i    (seg_noexec_i),
    .perm_o      (perm_o)
  );

  pgprot_fault u_fault (
    .req_i        (req_valid_i),
    .acc_i        (acc_type_i),
    .seg_hit_i    (seg_hit_i),
    .seg_nx_i     (seg_noexec_i),
    .pte_hit_i    (pte_hit_i),
    .perm_i       (perm_o),
    .viol_o       (viol_o),
    .fault_o      (fault_o),
    .class_o      (fault_class_o),
    .syn_o        (syndrome_o),
    .data_fault_o (data_fault)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         fault_addr_q <= '0;
    else if (data_fault) fault_addr_q <= addr_i;
  end

  assign fault_addr_o = fault_addr_q;
endmodule

// File: rtl/pgprot_chk.sv
`timescale 1ns/1ps
module pgprot_chk #(
  parameter int unsigned ADDR_W = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [1:0]        acc_type_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              seg_hit_i,
  input logic              seg_noexec_i,
  input logic              pte_noexec_i,
  input logic              pte_guard_i,
  input logic [2:0]        perm_o,
  input logic              viol_o,
  input logic              fault_o,
  input logic [2:0]        fault_class_o,
  input logic [31:0]       syndrome_o,
  input logic [ADDR_W-1:0] fault_addr_o
);
  logic dfault;
  assign dfault = fault_o && (fault_class_o == 3'd2 || fault_class_o == 3'd4);

  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fault_o |-> (syndrome_o == '0 && fault_class_o == '0)); // R11

  AST_WR_IMPLIES_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    perm_o[1] |-> perm_o[0]); // R3 R4

  AST_NX_BLOCKS_EXEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pte_noexec_i || pte_guard_i || seg_noexec_i) |-> !perm_o[2]); // R5

  AST_VIOL_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o |-> req_valid_i); // R6

  AST_FETCH_CLASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o && acc_type_i == 2'd2) |-> (fault_class_o == 3'd1 || fault_class_o == 3'd3)); // R7

  AST_SEG_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !seg_hit_i) |-> (fault_o && syndrome_o == '0 &&
      (fault_class_o == 3'd3 || fault_class_o == 3'd4))); // R9

  AST_ADDR_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dfault |=> (fault_addr_o == $past(addr_i))); // R10

  AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dfault |=> $stable(fault_addr_o)); // R10
endmodule

bind pgprot_top pgprot_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_valid_i   (req_valid_i),
  .acc_type_i    (acc_type_i),
  .addr_i        (addr_i),
  .seg_hit_i     (seg_hit_i),
  .seg_noexec_i  (seg_noexec_i),
  .pte_noexec_i  (pte_noexec_i),
  .pte_guard_i   (pte_guard_i),
  .perm_o        (perm_o),
  .viol_o        (viol_o),
  .fault_o       (fault_o),
  .fault_class_o (fault_class_o),
  .syndrome_o    (syndrome_o),
  .fault_addr_o  (fault_addr_o)
);

// File: tb/pgprot_top_tb_top.sv
`timescale 1ns/1ps
module pgprot_top_tb_top;
  localparam int unsigned AW = 64;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_valid_i = 1'b0;
  logic [1:0]    acc_type_i = '0;
  logic          priv_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          seg_hit_i = 1'b1;
  logic          seg_key_user_i = 1'b0;
  logic          seg_key_sup_i = 1'b0;
  logic          seg_noexec_i = 1'b0;
  logic          pte_hit_i = 1'b1;
  logic [1:0]    pte_pp_i = '0;
  logic          pte_pp_hi_i = 1'b0;
  logic          pte_noexec_i = 1'b0;
  logic          pte_guard_i = 1'b0;
  logic [2:0]    perm_o;
  logic          viol_o;
  logic          fault_o;
  logic [2:0]    fault_class_o;
  logic [31:0]   syndrome_o;
  logic [AW-1:0] fault_addr_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk_i = ~clk_i;

  pgprot_top #(.ADDR_W(AW)) dut_i (.*);

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  function automatic logic [2:0] exp_perm(input logic key, input logic [2:0] code, input logic nx_any);
    logic rw, ro;
    if (key == 1'b0) begin
      rw = (code == 3'd0) || (code == 3'd1) || (code == 3'd2);
      ro = (code == 3'd3) || (code == 3'd6);
    end else begin
      rw = (code == 3'd2);
      ro = (code == 3'd1) || (code == 3'd3);
    end
    return {~nx_any, rw, rw | ro};
  endfunction

  task automatic quiet();
    @(negedge clk_i);
    req_valid_i = 0; acc_type_i = 0; seg_hit_i = 1; pte_hit_i = 1;
    seg_noexec_i = 0; pte_noexec_i = 0; pte_guard_i = 0;
    priv_i = 0; seg_key_user_i = 0; seg_key_sup_i = 0;
    pte_pp_i = 0; pte_pp_hi_i = 0;
  endtask

  task automatic t_reset();
    #1;
    chk("R10 reset fault_addr", fault_addr_o, 0);
    chk("R11 reset fault", fault_o, 0);
    chk("R11 reset syndrome", syndrome_o, 0);
    chk("R11 reset class", fault_class_o, 0);
  endtask

  // R2 R3 R4: every code under both keys, both privilege levels
  task automatic t_tables();
    for (int p = 0; p < 2; p++) begin
      for (int k = 0; k < 2; k++) begin
        for (int c = 0; c < 8; c++) begin
          @(negedge clk_i);
          priv_i = p[0];
          seg_key_user_i = p[0] ? ~k[0] : k[0];
          seg_key_sup_i  = p[0] ? k[0] : ~k[0];
          pte_pp_hi_i = c[2];
          pte_pp_i = c[1:0];
          #1;
          chk(k == 0 ? "R3 key0 table" : "R4 key1 table", perm_o, exp_perm(k[0], c[2:0], 1'b0));
        end
      end
    end
  endtask

  // R1: the key chosen follows privilege
  task automatic t_key_sel();
    quiet();
    pte_pp_hi_i = 0; pte_pp_i = 2'd0;
    priv_i = 1; seg_key_sup_i = 1; seg_key_user_i = 0;
    #1; chk("R1 privileged uses sup key", perm_o, 3'b100);
    @(negedge clk_i);
    priv_i = 0;
    #1; chk("R1 unprivileged uses user key", perm_o, 3'b111);
    @(negedge clk_i);
    seg_key_user_i = 1;
    #1; chk("R1 user key set", perm_o, 3'b100);
  endtask

  task automatic t_exec();
    quiet();
    pte_pp_i = 2'd2;
    for (int m = 0; m < 8; m++) begin
      @(negedge clk_i);
      pte_noexec_i = m[0]; pte_guard_i = m[1]; seg_noexec_i = m[2];
      #1; chk("R5 exec gate", perm_o, exp_perm(1'b0, 3'd2, m != 0));
    end
  endtask

  task automatic t_viol();
    quiet();
    req_valid_i = 1; pte_pp_hi_i = 0; pte_pp_i = 2'd3; pte_guard_i = 1;
    acc_type_i = 0; #1; chk("R6 read on read-only", viol_o, 0);
    @(negedge clk_i); acc_type_i = 1; #1; chk("R6 write on read-only", viol_o, 1);
    @(negedge clk_i); acc_type_i = 2; #1; chk("R6 fetch guarded", viol_o, 1);
    @(negedge clk_i); acc_type_i = 3; #1; chk("R6 type3 as read", viol_o, 0);
    @(negedge clk_i); seg_key_user_i = 1; pte_pp_i = 2'd0; #1;
    chk("R6 type3 no access", viol_o, 1);
    @(negedge clk_i); req_valid_i = 0; #1; chk("R11 viol idle", viol_o, 0);
  endtask

  task automatic t_fetch();
    quiet();
    req_valid_i = 1; acc_type_i = 2;
    seg_hit_i = 0; #1;
    chk("R9 fetch seg miss class", fault_class_o, 3); chk("R9 fetch seg miss syn", syndrome_o, 0);
    @(negedge clk_i); seg_hit_i = 1; seg_noexec_i = 1; pte_hit_i = 0; #1;
    chk("R7 seg noexec syn", syndrome_o, 32'h1000_0000); chk("R7 seg noexec class", fault_class_o, 1);
    @(negedge clk_i); seg_noexec_i = 0; #1;
    chk("R7 fetch pte miss", syndrome_o, 32'h4000_0000);
    @(negedge clk_i); pte_hit_i = 1; pte_guard_i = 1; #1;
    chk("R7 fetch rights", syndrome_o, 32'h0800_0000); chk("R7 fetch rights class", fault_class_o, 1);
    @(negedge clk_i); pte_guard_i = 0; #1;
    chk("R7 fetch ok", fault_o, 0);
  endtask

  task automatic t_data();
    quiet();
    req_valid_i = 1; acc_type_i = 0; pte_hit_i = 0; seg_noexec_i = 1; #1;
    chk("R8 read pte miss", syndrome_o, 32'h4000_0000); chk("R8 read class", fault_class_o, 2);
    @(negedge clk_i); acc_type_i = 1; #1;
    chk("R8 write pte miss", syndrome_o, 32'h4200_0000);
    @(negedge clk_i); pte_hit_i = 1; pte_pp_i = 2'd3; #1;
    chk("R8 write rights", syndrome_o, 32'h0A00_0000);
    @(negedge clk_i); acc_type_i = 0; seg_key_user_i = 1; pte_pp_i = 2'd0; #1;
    chk("R8 read rights", syndrome_o, 32'h0800_0000);
    @(negedge clk_i); acc_type_i = 3; #1;
    chk("R8 type3 rights", syndrome_o, 32'h0800_0000);
    @(negedge clk_i); acc_type_i = 1; seg_hit_i = 0; #1;
    chk("R9 data seg miss class", fault_class_o, 4); chk("R9 data seg miss syn", syndrome_o, 0);
  endtask

  task automatic t_latch();
    quiet();
    req_valid_i = 1; acc_type_i = 0; pte_hit_i = 0; addr_i = 64'hA5A5_0000_1234_5678;
    @(posedge clk_i); #1; chk("R10 capture data fault", fault_addr_o, 64'hA5A5_0000_1234_5678);
    @(negedge clk_i); acc_type_i = 2; addr_i = 64'h1111;
    @(posedge clk_i); #1; chk("R10 fetch fault no capture", fault_addr_o, 64'hA5A5_0000_1234_5678);
    @(negedge clk_i); acc_type_i = 0; pte_hit_i = 1; addr_i = 64'h2222;
    @(posedge clk_i); #1; chk("R10 no fault hold", fault_addr_o, 64'hA5A5_0000_1234_5678);
    @(negedge clk_i); seg_hit_i = 0; acc_type_i = 1; addr_i = 64'hDEAD_BEEF;
    @(posedge clk_i); #1; chk("R10 seg miss capture", fault_addr_o, 64'hDEAD_BEEF);
    @(negedge clk_i); req_valid_i = 0; addr_i = 64'h3333;
    @(posedge clk_i); #1; chk("R10 idle hold", fault_addr_o, 64'hDEAD_BEEF);
  endtask

  task automatic t_idle();
    quiet();
    seg_hit_i = 0; pte_hit_i = 0; acc_type_i = 2; #1;
    chk("R11 idle fault", fault_o, 0);
    chk("R11 idle syndrome", syndrome_o, 0);
    chk("R11 idle class", fault_class_o, 0);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_tables();
    t_key_sel();
    t_exec();
    t_viol();
    t_fetch();
    t_data();
    t_latch();
    t_idle();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule